// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This peripheral keeps time as a free-running 32-bit count of seconds. A slow tick input, one rising edge per second, advances the count. Software reads and writes the block through a small synchronous register bus. The bus carries a byte offset, a write strobe and write data, and read data is returned combinationally. Software can preload the count, program an alarm value and arm two event sources.

After each increment, the new count is compared with the alarm value. When the alarm is armed and the two are equal, a sticky alarm flag is raised. A second sticky flag is raised on every tick while the per-second event is armed. Both flags drive level interrupt lines towards an interrupt controller. Software clears each flag by writing a one to its bit. A trim word is stored and read back, but it has no effect on timing.

The register bus is plain control access with no valid/ready handshake. A write takes effect on the clock edge that samples the strobe. A read returns the addressed register in the same cycle with no back-pressure.

Top module: `secs_rtc`

## Requirements
- R1: After reset, every register (alarm 0x00, counter 0x04, trim 0x08, status 0x10) reads zero, and both interrupt outputs are low.
- R2: Each rising edge of `tick_i` increments the counter by one, wrapping from 0xFFFFFFFF to 0. A tick held high for several cycles counts once.
- R3: The alarm register is at byte offset 0x00, the counter at 0x04, trim at 0x08 and status at 0x10. Any other offset reads zero, and writes to it change no register.
- R4: After an increment, the alarm flag (status bit 0) is set if the alarm enable (status bit 2) is one and the new count equals the alarm register.
- R5: On every tick edge where the tick enable (status bit 3) is one, the tick flag (status bit 1) is set, whatever the alarm comparison gives.
- R6: Writing status clears bit 0 and/or bit 1 wherever the written data has a one, and leaves them unchanged where it has a zero. The same write loads the alarm enable from data bit 2 and the tick enable from data bit 3.
- R7: Status bits 31 to 4 always read zero, whatever is written.
- R8: A trim write stores only data bits 25 to 0, and bits 31 to 26 read zero.
- R9: `irq_alarm` equals the alarm flag and `irq_tick` equals the tick flag. Both may be high together.
- R10: If a status write clearing a flag falls in the same cycle as a tick edge that sets that flag, the flag ends set.
- R11: A counter write in the same cycle as a tick edge loads the written value instead of incrementing, and no alarm comparison is made in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Once-per-second tick, counted on its rising edge |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_alarm | output | 1 | Alarm interrupt, level |
| irq_tick | output | 1 | Per-second interrupt, level |

## Verification
The properties assume that `tick_i` is synchronous to `clk`. They also assume that no tick edge coincides with an alarm-register write, whose compare outcome is not specified. The bench drives all inputs on the falling edge and never writes the alarm in a tick cycle. Collisions of a tick with counter or status writes are driven on purpose, because the set-wins and load-wins rules cover them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int OFF_ALARM = 'h00;
  localparam int OFF_COUNT = 'h04;
  localparam int OFF_TRIM  = 'h08;
  localparam int OFF_STAT  = 'h10;
  // status bit positions, decoded by software and the interrupt controller
  localparam int B_AL  = 0;
  localparam int B_HZ  = 1;
  localparam int B_ALE = 2;
  localparam int B_HZE = 3;
  localparam int STAT_W = 4;
endpackage

// File: rtl/rtc_tick_edge.sv
module rtc_tick_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic edge_o
);
  logic tick_q;
  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_i;
  end
  assign edge_o = tick_i & ~tick_q;
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic [W-1:0] alarm_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nx;
  assign cnt_nx = cnt_q + W'(1);
  // compare against the value the increment produces; a load suppresses it
  assign hit_o  = step_i && !load_i && (cnt_nx == alarm_i);
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= cnt_nx;
  end
  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic              step_i,
  input  logic              hit_i,
  output logic [STAT_W-1:0] stat_o
);
  logic al_q, hz_q, ale_q, hze_q;
  logic clr_al, clr_hz, set_al, set_hz;
  assign clr_al = wr_i && wdata_i[B_AL];
  assign clr_hz = wr_i && wdata_i[B_HZ];
  assign set_al = hit_i && ale_q;
  assign set_hz = step_i && hze_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_q  <= 1'b0;
      hz_q  <= 1'b0;
      ale_q <= 1'b0;
      hze_q <= 1'b0;
    end else begin
      // a set in the same cycle overrides a clear
      al_q <= set_al | (al_q & ~clr_al);
      hz_q <= set_hz | (hz_q & ~clr_hz);
      if (wr_i) begin
        ale_q <= wdata_i[B_ALE];
        hze_q <= wdata_i[B_HZE];
      end
    end
  end
  always_comb begin
    stat_o        = '0;
    stat_o[B_AL]  = al_q;
    stat_o[B_HZ]  = hz_q;
    stat_o[B_ALE] = ale_q;
    stat_o[B_HZE] = hze_q;
  end
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int TRIM_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_alarm,
  output logic              irq_tick
);
  logic              tick_edge;
  logic              wr_alarm, wr_cnt, wr_trim, wr_stat;
  logic [DATA_W-1:0] alarm_q;
  logic [TRIM_W-1:0] trim_q;
  logic [DATA_W-1:0] cnt_q;
  logic              hit;
  logic [STAT_W-1:0] stat;

  assign wr_alarm = bus_we && (bus_addr == ADDR_W'(OFF_ALARM));
  assign wr_cnt   = bus_we && (bus_addr == ADDR_W'(OFF_COUNT));
  assign wr_trim  = bus_we && (bus_addr == ADDR_W'(OFF_TRIM));
  assign wr_stat  = bus_we && (bus_addr == ADDR_W'(OFF_STAT));

  rtc_tick_edge u_edge (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .edge_o(tick_edge)
  );

  rtc_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(wr_cnt), .load_val_i(bus_wdata),
    .step_i(tick_edge), .alarm_i(alarm_q), .cnt_o(cnt_q), .hit_o(hit)
  );

  rtc_status u_stat (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_stat), .wdata_i(bus_wdata[STAT_W-1:0]),
    .step_i(tick_edge), .hit_i(hit), .stat_o(stat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q <= '0;
      trim_q  <= '0;
    end else begin
      if (wr_alarm) alarm_q <= bus_wdata;
      if (wr_trim)  trim_q  <= bus_wdata[TRIM_W-1:0];
    end
  end

  always_comb begin
    if (bus_addr == ADDR_W'(OFF_ALARM))      bus_rdata = alarm_q;
    else if (bus_addr == ADDR_W'(OFF_COUNT)) bus_rdata = cnt_q;
    else if (bus_addr == ADDR_W'(OFF_TRIM))  bus_rdata = DATA_W'(trim_q);
    else if (bus_addr == ADDR_W'(OFF_STAT))  bus_rdata = DATA_W'(stat);
    else                                     bus_rdata = '0;
  end

  assign irq_alarm = stat[B_AL];
  assign irq_tick  = stat[B_HZ];
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_edge,
  input logic         wr_cnt,
  input logic         wr_stat,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] alarm_q,
  input logic [3:0]   stat,
  input logic         irq_alarm,
  input logic         irq_tick
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_edge && !wr_cnt |=> cnt_q == $past(cnt_q) + W'(1));
  // R11
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wdata));
  // R4
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_edge && !wr_cnt && stat[2] && (cnt_q + W'(1) == alarm_q) |=> irq_alarm);
  // R4
  alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_alarm && !(tick_edge && !wr_cnt && stat[2]) |=> !irq_alarm);
  // R5
  hz_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_edge && stat[3] |=> irq_tick);
  // R6
  al_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_alarm && !(wr_stat && wdata[0]) |=> irq_alarm);
  // R6
  hz_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tick && !(wr_stat && wdata[1]) |=> irq_tick);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_edge && stat[3] && wr_stat && wdata[1] |=> irq_tick);
endmodule

bind secs_rtc rtc_chk #(.W(DATA_W)) u_rtc_chk (
  .clk(clk), .rst_n(rst_n), .tick_edge(tick_edge), .wr_cnt(wr_cnt),
  .wr_stat(wr_stat), .wdata(bus_wdata), .cnt_q(cnt_q), .alarm_q(alarm_q),
  .stat(stat), .irq_alarm(irq_alarm), .irq_tick(irq_tick)
);

// File: tb/test_secs_rtc.sv
module test_secs_rtc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_alarm, irq_tick;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  secs_rtc i_secs_rtc (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_alarm(irq_alarm), .irq_tick(irq_tick)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 32; a += 4) rd_chk("R1", 5'(a), 32'h0);
    check("R1 irq", {30'h0, irq_tick, irq_alarm}, 32'h0);

    // R3 unmapped offsets: write, then all registers still zero
    for (int a = 0; a < 32; a += 4)
      if (a != 'h00 && a != 'h04 && a != 'h08 && a != 'h10) wr(5'(a), 32'hFFFF_FFFF);
    for (int a = 0; a < 32; a += 4) rd_chk("R3", 5'(a), 32'h0);

    // R3 mapped offsets / R8 trim width
    wr(5'h00, 32'h1234_5678);
    wr(5'h08, 32'hFFFF_FFFF);
    rd_chk("R3 alarm", 5'h00, 32'h1234_5678);
    rd_chk("R8 trim", 5'h08, 32'h03FF_FFFF);
    wr(5'h08, 32'hA5A5_A5A5);
    rd_chk("R8 trim", 5'h08, 32'h01A5_A5A5);

    // R7 upper status bits
    wr(5'h10, 32'hFFFF_FFFF);
    rd_chk("R7", 5'h10, 32'h0000_000C);
    wr(5'h10, 32'h0);
    rd_chk("R7", 5'h10, 32'h0);

    // R2 wrap and held tick
    wr(5'h04, 32'hFFFF_FFFE);
    tick();
    rd_chk("R2", 5'h04, 32'hFFFF_FFFF);
    tick();
    rd_chk("R2 wrap", 5'h04, 32'h0);
    @(negedge clk); tick_i = 1'b1;
    repeat (5) @(negedge clk);
    tick_i = 1'b0;
    @(negedge clk);
    rd_chk("R2 held", 5'h04, 32'h1);

    // R4 R5 R9 sweep over enables and alarm distance
    for (int en = 0; en < 4; en++) begin
      for (int d = 0; d < 4; d++) begin
        logic [31:0] base;
        base = 32'(100 * (en + 1) + 10 * d);
        wr(5'h04, base);
        wr(5'h00, base + 32'(d));
        wr(5'h10, 32'(en << 2) | 32'h3);
        for (int k = 1; k <= 3; k++) begin
          logic eal, ehz;
          tick();
          eal = en[0] && d >= 1 && d <= k;
          ehz = en[1];
          rd_chk("R4 R5 status", 5'h10, {28'h0, en[1], en[0], ehz, eal});
          check("R9 irq", {30'h0, irq_tick, irq_alarm}, {30'h0, ehz, eal});
        end
        rd_chk("R2 count", 5'h04, base + 32'd3);
      end
    end

    // R6 write-one-to-clear, both flags set now (en=3 d=3)
    rd_chk("R9 both", 5'h10, 32'hF);
    wr(5'h10, 32'h0000_000C);
    rd_chk("R6 zero keeps", 5'h10, 32'hF);
    wr(5'h10, 32'h0000_000E);
    rd_chk("R6 clr hz", 5'h10, 32'hD);
    wr(5'h10, 32'h0000_0001);
    rd_chk("R6 clr al, enables loaded", 5'h10, 32'h0);

    // R10 set wins over clear
    wr(5'h10, 32'h0000_0008);
    tick();
    rd_chk("R10 pre", 5'h10, 32'hA);
    @(negedge clk);
    tick_i = 1'b1; bus_addr = 5'h10; bus_we = 1'b1; bus_wdata = 32'h0000_000A;
    @(negedge clk);
    tick_i = 1'b0; bus_we = 1'b0;
    rd_chk("R10", 5'h10, 32'hA);

    // R11 load beats tick, no compare
    wr(5'h10, 32'h0000_0007);
    wr(5'h00, 32'd50);
    wr(5'h04, 32'd48);
    @(negedge clk);
    tick_i = 1'b1; bus_addr = 5'h04; bus_we = 1'b1; bus_wdata = 32'd49;
    @(negedge clk);
    tick_i = 1'b0; bus_we = 1'b0;
    rd_chk("R11 load", 5'h04, 32'd49);
    rd_chk("R11 no alarm", 5'h10, 32'h4);
    @(negedge clk);
    tick_i = 1'b1; bus_addr = 5'h04; bus_we = 1'b1; bus_wdata = 32'd50;
    @(negedge clk);
    tick_i = 1'b0; bus_we = 1'b0;
    rd_chk("R11 load eq", 5'h04, 32'd50);
    rd_chk("R11 no compare", 5'h10, 32'h4);
    wr(5'h04, 32'd49);
    tick();
    rd_chk("R4 after load", 5'h10, 32'h5);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule